// File: doc/BRIEF.md
# Multi-Channel DAC Serial Command Sequencer

This block is a bus master for a serial multi-channel DAC. A host hands it one request at a time. A request can be a single channel-register write, a write of both offset DACs, a readback of one device register, or a batch update. The sequencer builds the 24-bit command frames, shifts them out over a four-wire SPI link and samples the return line. When a request completes it raises a one-cycle completion pulse, and after a readback it presents the 16-bit result.

A batch update takes its channel values from a stream, with a final-beat flag. Channel indices are assigned internally, counting up from zero. After the last frame the sequencer waits out the converter's busy time and then pulses the active-low load strobe, so that all outputs change together. Write frames and read-capture frames use separate serial clock rates. A minimum chip-select high time is enforced between frames.

Top module: `dac_spi_sequencer`

## Requirements
- R1: Frames are 24 bits, most significant bit first. The serial clock idles low. MOSI changes only on a rising clock edge, MISO is sampled on the falling edge, and the clock stays low while chip select is high.
- R2: A single write (`req_op` = 0) sends one frame. Bits [23:22] carry `req_cmd` (3 data, 2 offset, 1 gain). Bits [21:16] carry (`req_chan` + 8) mod 64, and bits [15:0] carry `req_value`.
- R3: An offset write (`req_op` = 1) sends two frames. Both have bits [23:22] = 0, bits [15:14] = 0 and bits [13:0] = `req_value[13:0]`. Bits [21:16] are 2 in the first frame and 3 in the second.
- R4: A readback (`req_op` = 2) first sends a request frame: bits [23:22] = 0, bits [21:16] = 5, bits [6:0] = 0, and a 9-bit selector in bits [15:7]. For `req_rsel` 0..3 the selector is `req_rsel`×64 + (`req_chan` + 8) mod 64. For 4, 5 and 6 it is 0x101, 0x102 and 0x103, and 7 maps to 0x101.
- R5: The second readback frame is all zeros. During it, 24 MISO bits are captured and the last 16 appear on `rd_data` with `done`. `rd_data` changes only when a readback completes.
- R6: Chip select is low for exactly 49×H system cycles per frame. H is WR_HALF for write and request frames and RD_HALF for the readback capture frame.
- R7: Chip select stays high for at least CS_GAP cycles between consecutive frames.
- R8: A batch (`req_op` = 3) sends one frame per stream beat, encoded as in R2 with the request's `req_cmd`. Channels run 0, 1, 2, … in beat order, and the beat with `bat_last` high is the final frame.
- R9: After a batch's final frame, `ldac_n` falls between BUSY_WAIT and BUSY_WAIT+CS_GAP+1 cycles after chip select rises. It stays low for exactly LDAC_LOW cycles.
- R10: `ldac_n` is high from reset and is never pulsed by single writes, offset writes or readbacks.
- R11: `req_ready` is high only when the sequencer is idle and drops after a request is accepted. `bat_ready` is never high together with `req_ready`. `done` is a single-cycle pulse.
- R12: After reset, `cs_n` and `ldac_n` are 1, `sclk`, `mosi`, `done`, `bat_ready` and `rd_data` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 write, 1 offsets, 2 readback, 3 batch |
| req_cmd | input | 2 | Register kind for writes and batches |
| req_chan | input | 6 | Channel number |
| req_value | input | 16 | Write value (offsets use low 14 bits) |
| req_rsel | input | 3 | Readback register selector kind |
| bat_valid | input | 1 | Batch value offered |
| bat_ready | output | 1 | Sequencer waiting for a batch value |
| bat_value | input | 16 | Batch channel value |
| bat_last | input | 1 | Final beat of the batch |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Readback result |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the DAC |
| miso | input | 1 | Serial data from the DAC |
| ldac_n | output | 1 | Active-low load strobe |

## Verification
Each result has a fixed due cycle. For a frame, chip select falls one cycle after acceptance and stays low for 49×H cycles. The load strobe falls BUSY_WAIT+CS_GAP+1 cycles after the last frame's chip select rises. Read data is due in the same cycle as `done`. A monitor samples every output on the falling system clock edge, counts chip-select-low, chip-select-high and strobe-low cycles exactly, and compares each captured frame with a value the bench computes arithmetically from the requirement encodings. The bench never waits a guessed delay: it waits for `done` with a bound and then compares the frame log and the counters.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    localparam int FRAME_W = 24;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_OFFSETS = 2'd1,
        OP_READ    = 2'd2,
        OP_BATCH   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        KIND_SPECIAL = 2'd0,
        KIND_GAIN    = 2'd1,
        KIND_OFFSET  = 2'd2,
        KIND_DATA    = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        SEL_X1A, SEL_X1B, SEL_OFS, SEL_GAIN,
        SEL_CTRL, SEL_OFSDAC0, SEL_OFSDAC1, SEL_SPARE
    } rsel_e;

    typedef struct packed {
        op_e         op;
        kind_e       kind;
        logic [5:0]  chan;
        logic [15:0] value;
        rsel_e       rsel;
    } req_t;

    // special-function codes, placed in bits [21:16]
    localparam logic [5:0] FN_OFSDAC0 = 6'd2;
    localparam logic [5:0] FN_OFSDAC1 = 6'd3;
    localparam logic [5:0] FN_READREQ = 6'd5;

    function automatic frame_t chan_frame(kind_e k, logic [5:0] ch, logic [15:0] v);
        logic [5:0] addr;
        addr = ch + 6'd8;
        return {k, addr, v};
    endfunction

    function automatic frame_t ofsdac_frame(logic [5:0] fn, logic [13:0] v);
        return {KIND_SPECIAL, fn, 2'b00, v};
    endfunction

    function automatic logic [8:0] read_sel(rsel_e s, logic [5:0] ch);
        logic [5:0] addr;
        addr = ch + 6'd8;
        case (s)
            SEL_X1A, SEL_X1B, SEL_OFS, SEL_GAIN: return {1'b0, s[1:0], addr};
            SEL_OFSDAC0: return 9'h102;
            SEL_OFSDAC1: return 9'h103;
            default:     return 9'h101;
        endcase
    endfunction

    function automatic frame_t first_frame(req_t r);
        case (r.op)
            OP_OFFSETS: return ofsdac_frame(FN_OFSDAC0, r.value[13:0]);
            OP_READ:    return {KIND_SPECIAL, FN_READREQ, read_sel(r.rsel, r.chan), 7'd0};
            default:    return chan_frame(r.kind, r.chan, r.value);
        endcase
    endfunction

endpackage

// File: rtl/dacseq_shifter.sv
module dacseq_shifter
    import dacseq_pkg::*;
#(
    parameter int WR_HALF = 4,
    parameter int RD_HALF = 7,
    parameter int CS_GAP  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        rd_speed,
    input  frame_t      tx_frame,
    input  logic        miso,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    output logic        fin,
    output logic [15:0] rx_word
);
    localparam int HMAX  = (WR_HALF > RD_HALF) ? WR_HALF : RD_HALF;
    localparam int DMAX  = (HMAX > CS_GAP) ? HMAX : CS_GAP;
    localparam int DIV_W = $clog2(DMAX + 1);
    localparam int BIT_W = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_HIGH, SH_LOW, SH_GAP} sh_state_e;

    sh_state_e        st;
    logic [DIV_W-1:0] div, half, pick;
    logic [BIT_W-1:0] bits;
    frame_t           sh;

    assign pick = rd_speed ? DIV_W'(RD_HALF) : DIV_W'(WR_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            fin     <= 1'b0;
            div     <= '0;
            half    <= '0;
            bits    <= '0;
            sh      <= '0;
            rx_word <= '0;
        end else begin
            fin <= 1'b0;
            case (st)
                SH_IDLE: if (go) begin
                    sh   <= tx_frame;
                    half <= pick;
                    div  <= pick - 1'b1;
                    bits <= BIT_W'(FRAME_W);
                    cs_n <= 1'b0;
                    st   <= SH_LEAD;
                end
                SH_LEAD, SH_LOW: begin
                    if (div != '0) begin
                        div <= div - 1'b1;
                    end else if (bits == '0) begin
                        cs_n <= 1'b1;
                        mosi <= 1'b0;
                        div  <= DIV_W'(CS_GAP - 1);
                        st   <= SH_GAP;
                    end else begin
                        sclk <= 1'b1;
                        mosi <= sh[FRAME_W-1];
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                        div  <= half - 1'b1;
                        st   <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (div != '0) begin
                        div <= div - 1'b1;
                    end else begin
                        sclk    <= 1'b0;
                        rx_word <= {rx_word[14:0], miso};
                        bits    <= bits - 1'b1;
                        div     <= half - 1'b1;
                        st      <= SH_LOW;
                    end
                end
                SH_GAP: begin
                    if (div != '0) begin
                        div <= div - 1'b1;
                    end else begin
                        fin <= 1'b1;
                        st  <= SH_IDLE;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // R1
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R1
    edge_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !cs_n);

    // R7
    fin_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> cs_n);

endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int BUSY_WAIT = 188,
    parameter int LDAC_LOW  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  req_t        req_in,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        bat_valid,
    input  logic [15:0] bat_value,
    input  logic        bat_last,
    output logic        bat_ready,
    input  logic        fin,
    input  logic [15:0] rx_word,
    output logic        go,
    output logic        rd_speed,
    output frame_t      tx_frame,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        ldac_n
);
    localparam int CMAX  = (BUSY_WAIT > LDAC_LOW) ? BUSY_WAIT : LDAC_LOW;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef enum logic [2:0] {C_IDLE, C_SEND, C_FETCH, C_BUSY, C_LOAD} c_state_e;

    c_state_e         st;
    op_e              op_q;
    kind_e            kind_q;
    logic [13:0]      ofs_q;
    logic             step, last_q;
    logic [5:0]       idx;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (st == C_IDLE);
    assign bat_ready = (st == C_FETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            op_q     <= OP_WRITE;
            kind_q   <= KIND_SPECIAL;
            ofs_q    <= '0;
            step     <= 1'b0;
            last_q   <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            go       <= 1'b0;
            rd_speed <= 1'b0;
            tx_frame <= '0;
            done     <= 1'b0;
            rd_data  <= '0;
            ldac_n   <= 1'b1;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (st)
                C_IDLE: if (req_valid) begin
                    op_q     <= req_in.op;
                    kind_q   <= req_in.kind;
                    ofs_q    <= req_in.value[13:0];
                    step     <= 1'b0;
                    idx      <= '0;
                    rd_speed <= 1'b0;
                    if (req_in.op == OP_BATCH) begin
                        st <= C_FETCH;
                    end else begin
                        tx_frame <= first_frame(req_in);
                        go       <= 1'b1;
                        st       <= C_SEND;
                    end
                end
                C_SEND: if (fin) begin
                    case (op_q)
                        OP_OFFSETS: begin
                            if (!step) begin
                                step     <= 1'b1;
                                tx_frame <= ofsdac_frame(FN_OFSDAC1, ofs_q);
                                go       <= 1'b1;
                            end else begin
                                done <= 1'b1;
                                st   <= C_IDLE;
                            end
                        end
                        OP_READ: begin
                            if (!step) begin
                                step     <= 1'b1;
                                tx_frame <= '0;
                                rd_speed <= 1'b1;
                                go       <= 1'b1;
                            end else begin
                                rd_data <= rx_word;
                                done    <= 1'b1;
                                st      <= C_IDLE;
                            end
                        end
                        OP_BATCH: begin
                            if (last_q) begin
                                cnt <= CNT_W'(BUSY_WAIT - 1);
                                st  <= C_BUSY;
                            end else begin
                                st <= C_FETCH;
                            end
                        end
                        default: begin
                            done <= 1'b1;
                            st   <= C_IDLE;
                        end
                    endcase
                end
                C_FETCH: if (bat_valid) begin
                    tx_frame <= chan_frame(kind_q, idx, bat_value);
                    last_q   <= bat_last;
                    idx      <= idx + 1'b1;
                    rd_speed <= 1'b0;
                    go       <= 1'b1;
                    st       <= C_SEND;
                end
                C_BUSY: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        ldac_n <= 1'b0;
                        cnt    <= CNT_W'(LDAC_LOW - 1);
                        st     <= C_LOAD;
                    end
                end
                C_LOAD: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        ldac_n <= 1'b1;
                        done   <= 1'b1;
                        st     <= C_IDLE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // R11
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    ready_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && bat_ready));

endmodule

// File: rtl/dac_spi_sequencer.sv
module dac_spi_sequencer
    import dacseq_pkg::*;
#(
    parameter int WR_HALF   = 4,
    parameter int RD_HALF   = 7,
    parameter int CS_GAP    = 3,
    parameter int BUSY_WAIT = 188,
    parameter int LDAC_LOW  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [1:0]  req_cmd,
    input  logic [5:0]  req_chan,
    input  logic [15:0] req_value,
    input  logic [2:0]  req_rsel,
    input  logic        bat_valid,
    output logic        bat_ready,
    input  logic [15:0] bat_value,
    input  logic        bat_last,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso,
    output logic        ldac_n
);
    req_t        rq;
    logic        go, rd_speed, fin;
    frame_t      tx_frame;
    logic [15:0] rx_word;

    always_comb begin
        rq.op    = op_e'(req_op);
        rq.kind  = kind_e'(req_cmd);
        rq.chan  = req_chan;
        rq.value = req_value;
        rq.rsel  = rsel_e'(req_rsel);
    end

    dacseq_ctrl #(
        .BUSY_WAIT(BUSY_WAIT),
        .LDAC_LOW (LDAC_LOW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_in   (rq),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .bat_valid(bat_valid),
        .bat_value(bat_value),
        .bat_last (bat_last),
        .bat_ready(bat_ready),
        .fin      (fin),
        .rx_word  (rx_word),
        .go       (go),
        .rd_speed (rd_speed),
        .tx_frame (tx_frame),
        .done     (done),
        .rd_data  (rd_data),
        .ldac_n   (ldac_n)
    );

    dacseq_shifter #(
        .WR_HALF(WR_HALF),
        .RD_HALF(RD_HALF),
        .CS_GAP (CS_GAP)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .rd_speed(rd_speed),
        .tx_frame(tx_frame),
        .miso    (miso),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .fin     (fin),
        .rx_word (rx_word)
    );

    // R10
    ldac_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ldac_n |-> cs_n);

endmodule

// File: tb/dac_spi_sequencer_tb.sv
module dac_spi_sequencer_tb;

    localparam int WR_HALF   = 4;
    localparam int RD_HALF   = 7;
    localparam int CS_GAP    = 3;
    localparam int BUSY_WAIT = 188;
    localparam int LDAC_LOW  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [1:0]  req_cmd = '0;
    logic [5:0]  req_chan = '0;
    logic [15:0] req_value = '0;
    logic [2:0]  req_rsel = '0;
    logic        bat_valid = 1'b0;
    logic        bat_ready;
    logic [15:0] bat_value = '0;
    logic        bat_last = 1'b0;
    logic        done;
    logic [15:0] rd_data;
    logic        sclk, cs_n, mosi, ldac_n;
    logic        miso = 1'b0;

    always #5 clk = ~clk;

    dac_spi_sequencer #(
        .WR_HALF(WR_HALF), .RD_HALF(RD_HALF), .CS_GAP(CS_GAP),
        .BUSY_WAIT(BUSY_WAIT), .LDAC_LOW(LDAC_LOW)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_cmd(req_cmd), .req_chan(req_chan),
        .req_value(req_value), .req_rsel(req_rsel), .bat_valid(bat_valid),
        .bat_ready(bat_ready), .bat_value(bat_value), .bat_last(bat_last),
        .done(done), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .ldac_n(ldac_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // monitor state, written only by the monitor block
    int          nframes = 0;
    int          fr_val [512];
    int          fr_len [512];
    int          fr_bits[512];
    logic [23:0] cur = '0;
    int          nbits = 0, lowlen = 0, hilen = 0;
    int          min_gap = 1000000;
    bit          seen_frame = 1'b0;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0, p_ldac = 1'b1, p_done = 1'b0;
    int          edge_err = 0, dbl_done = 0;
    int          pulses = 0, ld_low = 0, ld_width = 0, ld_delay = 0;
    logic [23:0] miso_word = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n) begin
                if (p_cs) begin
                    if (seen_frame && hilen < min_gap) min_gap = hilen;
                    nbits = 0; cur = '0; lowlen = 0;
                end
                lowlen++;
                hilen = 0;
                if (sclk && !p_sclk) begin
                    cur = {cur[22:0], mosi};
                    nbits++;
                    if (nbits <= 24) miso = miso_word[24-nbits];
                end else if (mosi !== p_mosi) begin
                    edge_err++;
                end
            end else begin
                if (!p_cs) begin
                    if (nframes < 512) begin
                        fr_val[nframes]  = int'(cur);
                        fr_len[nframes]  = lowlen;
                        fr_bits[nframes] = nbits;
                    end
                    nframes++;
                    seen_frame = 1'b1;
                end
                hilen++;
                if (sclk) edge_err++;
            end
            if (!ldac_n && p_ldac) begin
                pulses++;
                ld_delay = hilen - 1;
                ld_low = 0;
            end
            if (!ldac_n) ld_low++;
            if (ldac_n && !p_ldac) ld_width = ld_low;
            if (done && p_done) dbl_done++;
        end
        p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_ldac = ldac_n; p_done = done;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    function automatic int exp_wr(int k, int ch, int v);
        return k * 4194304 + ((ch + 8) % 64) * 65536 + (v % 65536);
    endfunction

    function automatic int exp_ofs(int fn, int v);
        return fn * 65536 + (v % 16384);
    endfunction

    function automatic int exp_rd(int rs, int ch);
        int sel;
        if (rs < 4)       sel = rs * 64 + (ch + 8) % 64;
        else if (rs == 5) sel = 258;
        else if (rs == 6) sel = 259;
        else              sel = 257;
        return 5 * 65536 + sel * 128;
    endfunction

    task automatic send_req(input int op, input int k, input int ch, input int v, input int rs);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_cmd   = 2'(k);
        req_chan  = 6'(ch);
        req_value = 16'(v);
        req_rsel  = 3'(rs);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", "ready after accept", longint'(req_ready), 0);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R11", "done seen", longint'(done), 1);
    endtask

    task automatic chk_frame(input int i, input int exp_val, input int exp_len, input string tag);
        chk(fr_val[i] == exp_val, tag, "frame content", fr_val[i], exp_val);
        chk(fr_bits[i] == 24, "R1", "bits per frame", fr_bits[i], 24);
        chk(fr_len[i] == exp_len, "R6", "cs low length", fr_len[i], exp_len);
    endtask

    int chans[8] = '{0, 1, 7, 13, 31, 39, 55, 60};
    int ofsv[4]  = '{16'h1FFF, 16'h3FFF, 16'hFFFF, 16'h0000};

    initial begin
        int base, v, held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(cs_n == 1'b1, "R12", "cs_n", longint'(cs_n), 1);
        chk(sclk == 1'b0, "R12", "sclk", longint'(sclk), 0);
        chk(mosi == 1'b0, "R12", "mosi", longint'(mosi), 0);
        chk(ldac_n == 1'b1, "R12", "ldac_n", longint'(ldac_n), 1);
        chk(req_ready == 1'b1, "R12", "req_ready", longint'(req_ready), 1);
        chk(bat_ready == 1'b0, "R12", "bat_ready", longint'(bat_ready), 0);
        chk(done == 1'b0, "R12", "done", longint'(done), 0);
        chk(rd_data == 16'h0, "R12", "rd_data", longint'(rd_data), 0);

        // R2 single writes over all register kinds and a channel sweep
        for (int k = 1; k <= 3; k++) begin
            for (int c = 0; c < 8; c++) begin
                v = (chans[c] * 517 + k * 4099) % 65536;
                base = nframes;
                send_req(0, k, chans[c], v, 0);
                wait_done();
                @(negedge clk);
                chk(nframes - base == 1, "R2", "frame count", nframes - base, 1);
                chk_frame(base, exp_wr(k, chans[c], v), 49 * WR_HALF, "R2");
                chk(rd_data == 16'h0, "R5", "rd_data untouched by write", longint'(rd_data), 0);
            end
        end
        chk(pulses == 0, "R10", "no load pulse on writes", pulses, 0);

        // R3 offset DAC pair
        for (int i = 0; i < 4; i++) begin
            base = nframes;
            send_req(1, 0, 0, ofsv[i], 0);
            wait_done();
            @(negedge clk);
            chk(nframes - base == 2, "R3", "frame count", nframes - base, 2);
            chk_frame(base, exp_ofs(2, ofsv[i]), 49 * WR_HALF, "R3");
            chk_frame(base + 1, exp_ofs(3, ofsv[i]), 49 * WR_HALF, "R3");
        end

        // R4 R5 readback over every selector kind
        for (int rs = 0; rs < 8; rs++) begin
            for (int c = 0; c < 3; c++) begin
                if (rs < 4 || c == 0) begin
                    base = nframes;
                    miso_word = 24'(32'hA5_0000 ^ (rs * 32'h1111) ^ (chans[c * 2 + 1] * 32'h0F0F) ^ c);
                    send_req(2, 0, chans[c * 2 + 1], 0, rs);
                    wait_done();
                    chk(rd_data == miso_word[15:0], "R5", "read data at done",
                        longint'(rd_data), longint'(miso_word[15:0]));
                    @(negedge clk);
                    chk(nframes - base == 2, "R4", "frame count", nframes - base, 2);
                    chk_frame(base, exp_rd(rs, chans[c * 2 + 1]), 49 * WR_HALF, "R4");
                    chk_frame(base + 1, 0, 49 * RD_HALF, "R5");
                end
            end
        end
        // R5 hold across a non-read request
        held = int'(rd_data);
        send_req(0, 3, 2, 16'h1234, 0);
        wait_done();
        @(negedge clk);
        chk(int'(rd_data) == held, "R5", "rd_data held", longint'(rd_data), held);
        chk(pulses == 0, "R10", "no load pulse on offsets or reads", pulses, 0);

        // R8 R9 batches
        for (int b = 0; b < 2; b++) begin
            int n, k0;
            n = (b == 0) ? 6 : 1;
            k0 = (b == 0) ? 3 : 1;
            base = nframes;
            send_req(3, k0, 0, 0, 0);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                while (!bat_ready) @(negedge clk);
                chk(!req_ready, "R11", "req_ready low while fetching", longint'(req_ready), 0);
                bat_valid = 1'b1;
                bat_value = 16'((i * 7919 + b * 311 + 5) % 65536);
                bat_last  = (i == n - 1);
                @(negedge clk);
                bat_valid = 1'b0;
                bat_last  = 1'b0;
            end
            wait_done();
            @(negedge clk);
            chk(nframes - base == n, "R8", "batch frame count", nframes - base, n);
            for (int i = 0; i < n; i++)
                chk_frame(base + i, exp_wr(k0, i, (i * 7919 + b * 311 + 5) % 65536), 49 * WR_HALF, "R8");
            chk(pulses == b + 1, "R9", "load pulse count", pulses, b + 1);
            chk(ld_width == LDAC_LOW, "R9", "load low width", ld_width, LDAC_LOW);
            chk(ld_delay >= BUSY_WAIT && ld_delay <= BUSY_WAIT + CS_GAP + 1, "R9",
                "busy wait before load", ld_delay, BUSY_WAIT + CS_GAP + 1);
            chk(ldac_n == 1'b1, "R9", "load line released", longint'(ldac_n), 1);
        end

        chk(min_gap >= CS_GAP, "R7", "min cs high gap", min_gap, CS_GAP);
        chk(edge_err == 0, "R1", "mosi/sclk edge violations", edge_err, 0);
        chk(dbl_done == 0, "R11", "done wider than one cycle", dbl_done, 0);
        finish_run();
    end

endmodule